// File: doc/BRIEF.md
# Linked Load / Conditional Store Reservation Monitor

This block sits beside a CPU load-store unit and keeps one reservation for a linked-load / conditional-store pair. Every request carries an operation code, a byte address and a scope flag. A linked load reserves the whole address line it touches. A later conditional store succeeds only while that reservation is still intact. Normal loads pass through without any effect. A normal store that lands on the reserved line is handled by a policy pin: the store either completes and breaks the reservation, or it is blocked and an exception pulse is raised. Other agents report writes through a snoop port. A snoop breaks the reservation only when the reservation was taken with inter-CPU scope.

The request port is a valid/ready interface. `req_ready` is always high because the block never applies back-pressure: a request is accepted in every cycle in which `req_valid` is high. All results are combinational in the cycle of the request. The reservation state updates at the next clock edge. The policy pin and the snoop port are plain control inputs.

Top module: `resv_monitor`

## Requirements
- R1: After reset the reservation is clear, so the first conditional store fails and does not write.
- R2: A normal load (req_op 0) never asserts `mem_we`, `sc_done` or `exc_pulse`, and it leaves the reservation unchanged.
- R3: With `store_policy` 0, a normal store (req_op 1) always asserts `mem_we`. If it hits the reserved line, it clears the reservation.
- R4: With `store_policy` 1, a normal store that hits the reserved line asserts `exc_pulse`, does not write and keeps the reservation. A store that misses the line writes normally.
- R5: A linked load (req_op 2) writes nothing. It records the line address (`req_addr` bits above LINE_OFS_W) and the `req_inter` scope, and sets the lock. Any older reservation is replaced.
- R6: A conditional store (req_op 3) asserts `sc_done` in its request cycle. It succeeds only if all three hold: the lock is set, the line matches, and `req_inter` equals the recorded scope. On success it asserts `sc_ok` and `mem_we` in that same cycle.
- R7: A conditional store that does not succeed asserts neither `sc_ok` nor `mem_we`. Every conditional store clears the lock, whether it succeeds or fails.
- R8: Line matching ignores the low LINE_OFS_W address bits. Any byte in the reserved line counts as a hit.
- R9: A `snoop_valid` whose line matches the reservation clears the lock only if the reservation has inter-CPU scope (`req_inter` 1 at the linked load). A linked load in the same cycle wins over the snoop.
- R10: While `req_valid` is low, all result outputs stay low and the request fields have no effect. `req_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always high; no back-pressure |
| req_op | input | 2 | 0 load, 1 store, 2 linked load, 3 conditional store |
| req_addr | input | ADDR_W | Byte address of the request |
| req_inter | input | 1 | Scope: 1 inter-CPU, 0 intra-CPU only |
| store_policy | input | 1 | 0 store clears lock, 1 store to locked line raises exception |
| snoop_valid | input | 1 | Another agent wrote snoop_addr |
| snoop_addr | input | ADDR_W | Address written by the other agent |
| mem_we | output | 1 | Write enable to the memory side |
| sc_done | output | 1 | A conditional store was handled this cycle |
| sc_ok | output | 1 | That conditional store succeeded |
| exc_pulse | output | 1 | Store hit the locked line under exception policy |

## Verification
The bench sweeps every pairing of operation, policy and both scope flags against a grid of addresses inside and outside a reserved line. A conditional store then probes whether the lock survived. If line matching compared offset bits, same-line stores and conditional stores would miss. A design that kept the lock after a failed conditional store, or that let a normal load disturb it, would show up as a wrong probe result. A separate snoop sweep checks that an intra-scope reservation survives matching snoops and an inter-scope one does not. It also checks that a linked load issued with a snoop in the same cycle still holds.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    OP_LD = 2'd0,
    OP_ST = 2'd1,
    OP_LL = 2'd2,
    OP_SC = 2'd3
  } resv_op_e;
endpackage

// File: rtl/resv_line_match.sv
module resv_line_match #(
  parameter int ADDR_W     = 8,
  parameter int LINE_OFS_W = 2,
  localparam int TAG_W     = ADDR_W - LINE_OFS_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  tag,
  output logic              hit
);
  // only the line part of the address takes part in the compare
  assign hit = (addr[ADDR_W-1:LINE_OFS_W] == tag);
endmodule

// File: rtl/resv_holder.sv
module resv_holder #(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic             clr,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             set_inter,
  output logic             lock,
  output logic [TAG_W-1:0] tag,
  output logic             inter
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock  <= 1'b0;
      tag   <= '0;
      inter <= 1'b0;
    end else if (set) begin
      // a new linked load takes precedence over every clearing source
      lock  <= 1'b1;
      tag   <= set_tag;
      inter <= set_inter;
    end else if (clr) begin
      lock  <= 1'b0;
    end
  end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int ADDR_W     = 8,
  parameter int LINE_OFS_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_inter,
  input  logic              store_policy,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              mem_we,
  output logic              sc_done,
  output logic              sc_ok,
  output logic              exc_pulse
);
  import resv_pkg::*;

  localparam int TAG_W = ADDR_W - LINE_OFS_W;

  logic             lock_q, inter_q;
  logic [TAG_W-1:0] tag_q;
  logic             req_line_hit, snp_line_hit;
  logic             req_hit, snp_hit;
  logic             set_r, clr_r;
  resv_op_e         op;

  assign req_ready = 1'b1;
  assign op        = resv_op_e'(req_op);

  resv_line_match #(.ADDR_W(ADDR_W), .LINE_OFS_W(LINE_OFS_W)) u_req_match (
    .addr(req_addr), .tag(tag_q), .hit(req_line_hit)
  );

  resv_line_match #(.ADDR_W(ADDR_W), .LINE_OFS_W(LINE_OFS_W)) u_snp_match (
    .addr(snoop_addr), .tag(tag_q), .hit(snp_line_hit)
  );

  assign req_hit = lock_q & req_line_hit;
  // intra-CPU reservations are deaf to other agents
  assign snp_hit = snoop_valid & lock_q & inter_q & snp_line_hit;

  always_comb begin
    mem_we    = 1'b0;
    sc_done   = 1'b0;
    sc_ok     = 1'b0;
    exc_pulse = 1'b0;
    set_r     = 1'b0;
    clr_r     = 1'b0;
    if (req_valid) begin
      unique case (op)
        OP_LD: ;
        OP_ST: begin
          if (req_hit && store_policy) begin
            exc_pulse = 1'b1;
          end else begin
            mem_we = 1'b1;
            clr_r  = req_hit;
          end
        end
        OP_LL: set_r = 1'b1;
        OP_SC: begin
          sc_done = 1'b1;
          sc_ok   = req_hit && (req_inter == inter_q);
          mem_we  = sc_ok;
          clr_r   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  resv_holder #(.TAG_W(TAG_W)) u_holder (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (set_r),
    .clr      (clr_r | snp_hit),
    .set_tag  (req_addr[ADDR_W-1:LINE_OFS_W]),
    .set_inter(req_inter),
    .lock     (lock_q),
    .tag      (tag_q),
    .inter    (inter_q)
  );
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic       store_policy,
  input logic       mem_we,
  input logic       sc_done,
  input logic       sc_ok,
  input logic       exc_pulse
);
  // R2: loads are silent
  a_r2_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0) |-> (!mem_we && !sc_done && !exc_pulse));

  // R4: an exception only under exception policy, and never with a write
  a_r4_exc_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |-> (!mem_we && store_policy && req_valid && req_op == 2'd1));

  // R6: success always comes with a write and a done flag
  a_r6_ok_writes: assert property (@(posedge clk) disable iff (!rst_n)
    sc_ok |-> (mem_we && sc_done));

  // R7: a conditional store consumes the lock, so a back-to-back one fails
  a_r7_lock_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd3) |=> !sc_ok);

  // R10: no request, no result
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_we && !sc_done && !sc_ok && !exc_pulse));
endmodule

bind resv_monitor resv_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .store_policy(store_policy), .mem_we(mem_we), .sc_done(sc_done),
  .sc_ok(sc_ok), .exc_pulse(exc_pulse)
);

// File: tb/resv_monitor_tb_top.sv
`timescale 1ns/100ps
module resv_monitor_tb_top;
  localparam int AW  = 8;
  localparam int OFS = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic          req_inter = 1'b0;
  logic          store_policy = 1'b0;
  logic          snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          mem_we, sc_done, sc_ok, exc_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference state
  bit            m_lock = 1'b0;
  bit [AW-1:0]   m_line = '0;
  bit            m_inter = 1'b0;

  always #2.5 clk = ~clk;

  resv_monitor #(.ADDR_W(AW), .LINE_OFS_W(OFS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_inter(req_inter),
    .store_policy(store_policy), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .mem_we(mem_we), .sc_done(sc_done),
    .sc_ok(sc_ok), .exc_pulse(exc_pulse)
  );

  function automatic bit same_line(input bit [AW-1:0] a, input bit [AW-1:0] b);
    return (a >> OFS) == (b >> OFS);
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {we,done,ok,exc} actual %b expected %b", tag, act, exp);
    end
  endtask

  // one request cycle: drive, compare combinational results, update model
  task automatic step(input bit v, input bit [1:0] op, input bit [AW-1:0] a,
                      input bit sc, input bit pol, input bit sv,
                      input bit [AW-1:0] sa, input string tag_in);
    bit hit, we, done, ok, exc, set, clr;
    string tag;
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = a; req_inter = sc;
    store_policy = pol; snoop_valid = sv; snoop_addr = sa;
    #1;
    hit = m_lock && same_line(a, m_line);
    {we, done, ok, exc, set, clr} = '0;
    tag = tag_in;
    if (v) begin
      case (op)
        2'd0: if (tag == "") tag = "R2";
        2'd1: begin
          if (tag == "") tag = pol ? "R4" : "R3";
          if (hit && pol) exc = 1'b1;
          else begin we = 1'b1; clr = hit; end
        end
        2'd2: begin set = 1'b1; if (tag == "") tag = "R5"; end
        default: begin
          done = 1'b1;
          ok = hit && (sc == m_inter);
          we = ok;
          clr = 1'b1;
          if (tag == "") tag = (hit && a != m_line) ? "R8" : (ok ? "R6" : "R7");
        end
      endcase
    end else if (tag == "") tag = "R10";
    check(tag, {mem_we, sc_done, sc_ok, exc_pulse}, {we, done, ok, exc});
    if (req_ready !== 1'b1) check("R10", 4'd0, 4'd1);
    if (sv && m_lock && m_inter && same_line(sa, m_line)) clr = 1'b1;
    @(posedge clk);
    if (set) begin m_lock = 1'b1; m_line = a; m_inter = sc; end
    else if (clr) m_lock = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: lock starts clear
    step(1, 2'd3, 8'h00, 0, 0, 0, 8'h00, "R1");
    step(1, 2'd3, 8'h00, 1, 0, 0, 8'h00, "R1");

    // main sweep: reserve line of 0x24, apply op, probe with a conditional store
    for (int pol = 0; pol < 2; pol++)
      for (int lli = 0; lli < 2; lli++)
        for (int sci = 0; sci < 2; sci++)
          for (int op = 0; op < 4; op++)
            for (int a = 0; a < 256; a += 3) begin
              step(1, 2'd2, 8'h24, lli[0], pol[0], 0, 8'h00, "");
              step(1, op[1:0], a[7:0], sci[0], pol[0], 0, 8'h00, "");
              step(1, 2'd3, 8'h27, lli[0], pol[0], 0, 8'h00, "");
            end

    // R9: snoop sweep per scope
    for (int sc = 0; sc < 2; sc++)
      for (int a = 0; a < 256; a += 5) begin
        step(1, 2'd2, 8'h41, sc[0], 0, 0, 8'h00, "R5");
        step(0, 2'd3, 8'h41, sc[0], 0, 1, a[7:0], "R10");
        step(1, 2'd3, 8'h42, sc[0], 0, 0, 8'h00, "R9");
      end

    // R9: linked load in the same cycle as a matching snoop keeps the lock
    step(1, 2'd2, 8'h80, 1, 0, 1, 8'h81, "R9");
    step(1, 2'd3, 8'h83, 1, 0, 0, 8'h00, "R9");

    // R10: idle cycles with every opcode leave the lock alone
    step(1, 2'd2, 8'h10, 0, 0, 0, 8'h00, "R5");
    for (int op = 0; op < 4; op++)
      step(0, op[1:0], 8'h10, 0, 1, 0, 8'h00, "R10");
    step(1, 2'd3, 8'h11, 0, 0, 0, 8'h00, "R10");

    // R5: replacement of an older reservation
    step(1, 2'd2, 8'h10, 0, 0, 0, 8'h00, "R5");
    step(1, 2'd2, 8'hC0, 1, 0, 0, 8'h00, "R5");
    step(1, 2'd3, 8'h10, 0, 0, 0, 8'h00, "R5");
    step(1, 2'd2, 8'h10, 0, 0, 0, 8'h00, "R5");
    step(1, 2'd2, 8'hC0, 1, 0, 0, 8'h00, "R5");
    step(1, 2'd3, 8'hC3, 1, 0, 0, 8'h00, "R5");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule